// File: doc/BRIEF.md
# Device Error Signaling Controller

This block is the device-side flow that turns one detected error into status updates and, when the configuration allows, into an error message. An error arrives on a ready/valid injection port. It carries a status bit vector, a flag that says whether it is correctable, a flag that allows it to be downgraded to advisory, and a source identifier. The block keeps the sticky device-status detected bits and the correctable and uncorrectable status registers. It applies the mask and severity configuration, and it reports through a one-cycle log strobe whether the error must be recorded by the header-logging block next to it.

When a message is produced, a bridge-forwarding stage decides what happens at the port. It sets the received and signaled system-error flags and tells the consumer whether the message continues upstream. The message is held on a ready/valid output. While the message waits there, no new error is accepted. Configuration arrives on plain inputs driven by the surrounding register file.

Top module: `err_signal_ctrl`

## Requirements
- R1: The incoming vector is ANDed with the supported set. For correctable errors the supported bits are 0, 6, 7, 8, 12, 13, 14 and 15. For uncorrectable errors they are bits 4, 5 and 12 to 25. If the result has zero bits set or more than one bit set, the error is accepted but changes no register, raises no log strobe and produces no message.
- R2: With `cap_present` = 1, an uncorrectable error is fatal when its bit is set in `cfg_unc_sev`. With `cap_present` = 0, bits 4, 5, 13, 17, 18 and 22 are fatal and all others are non-fatal. In that case the status registers are left alone, masks are ignored and no log strobe is raised.
- R3: A correctable error sets `dev_sts[0]` and its bit in `cor_sts`. If that bit is set in `cfg_cor_mask`, no message is produced.
- R4: A correctable message (`msg_sev` = 0) is produced only when `cfg_cor_rep_en` = 1. For an unsupported request (uncorrectable bit 20) it also needs `cfg_ur_rep_en` = 1.
- R5: A non-fatal error injected with `inj_maybe_adv` = 1 is handled as a correctable error on bit 13. It sets `dev_sts[0]`, `cor_sts[13]` and its own bit in `unc_sts`. The log strobe is raised only when its bit in `cfg_unc_mask` is clear.
- R6: An uncorrectable error sets `dev_sts[2]` if it is fatal or `dev_sts[1]` if it is non-fatal, and sets `dev_sts[3]` when it is bit 20. It always sets its bit in `unc_sts`. If the error is masked, there is no log strobe and no message; otherwise the log strobe is raised.
- R7: An uncorrectable unsupported request produces no message when `cfg_ur_rep_en` and `cfg_serr_en` are both 0.
- R8: A fatal message (`msg_sev` = 2) needs `cfg_serr_en` or `cfg_fat_rep_en`. A non-fatal message (`msg_sev` = 1) needs `cfg_serr_en` or `cfg_nf_rep_en`.
- R9: When `port_is_bridge` = 1, an uncorrectable message sets `rcv_serr`. If `cfg_br_serr_en` = 0, `sig_serr` is not set and `msg_fwd` = 0.
- R10: An uncorrectable message that passes the bridge check, with `cfg_serr_en` = 1, sets `sig_serr`. `msg_fwd` is then 1 exactly when the matching reporting enable is set. A correctable message always has `msg_fwd` = 0.
- R11: `inj_ready` is low while `msg_valid` is high. A message keeps its severity and source steady until `msg_ready` is seen. `msg_src` equals the injected source.
- R12: `log_pulse` is high only in the single cycle that follows the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_valid | input | 1 | Error injection request |
| inj_ready | output | 1 | Block can take an error |
| inj_status | input | STS_W | Error status vector |
| inj_is_cor | input | 1 | Error is correctable |
| inj_maybe_adv | input | 1 | Non-fatal error may be downgraded to advisory |
| inj_src | input | SRC_W | Source identifier |
| cap_present | input | 1 | Mask/severity capability is implemented |
| cfg_unc_mask | input | STS_W | Uncorrectable mask |
| cfg_unc_sev | input | STS_W | Uncorrectable severity (1 = fatal) |
| cfg_cor_mask | input | STS_W | Correctable mask |
| cfg_cor_rep_en | input | 1 | Correctable reporting enable |
| cfg_nf_rep_en | input | 1 | Non-fatal reporting enable |
| cfg_fat_rep_en | input | 1 | Fatal reporting enable |
| cfg_ur_rep_en | input | 1 | Unsupported-request reporting enable |
| cfg_serr_en | input | 1 | System-error enable of the function |
| port_is_bridge | input | 1 | Function is a bridge or switch port |
| cfg_br_serr_en | input | 1 | Bridge system-error forwarding enable |
| dev_sts | output | 4 | Detected bits: 0 correctable, 1 non-fatal, 2 fatal, 3 unsupported request |
| cor_sts | output | STS_W | Correctable status |
| unc_sts | output | STS_W | Uncorrectable status |
| sig_serr | output | 1 | Signaled system error |
| rcv_serr | output | 1 | Received system error (secondary side) |
| log_pulse | output | 1 | Error must be logged |
| msg_valid | output | 1 | Message pending |
| msg_ready | input | 1 | Message taken |
| msg_sev | output | 2 | 0 correctable, 1 non-fatal, 2 fatal |
| msg_src | output | SRC_W | Message source identifier |
| msg_fwd | output | 1 | Message continues upstream |

## Verification
The handshake and forwarding properties assume that the configuration inputs stay constant while a message is held. They also assume that `msg_ready` is meaningful only while `msg_valid` is high. The stimulus changes configuration only between complete transactions, at the falling edge and with the block idle. It raises `msg_ready` for a single cycle after it has sampled a message. Each scenario starts from a fresh reset, so the sticky status registers begin at zero.

// File: rtl/err_sig_pkg.sv
package err_sig_pkg;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } sev_e;

  // uncorrectable bit positions
  localparam int UNC_DLP    = 4;
  localparam int UNC_SDN    = 5;
  localparam int UNC_POISON = 12;
  localparam int UNC_FCP    = 13;
  localparam int UNC_CTO    = 14;
  localparam int UNC_CA     = 15;
  localparam int UNC_UC     = 16;
  localparam int UNC_RXO    = 17;
  localparam int UNC_MALF   = 18;
  localparam int UNC_ECRC   = 19;
  localparam int UNC_UR     = 20;
  localparam int UNC_ACS    = 21;
  localparam int UNC_INT    = 22;
  localparam int UNC_MCB    = 23;
  localparam int UNC_ATOP   = 24;
  localparam int UNC_PFX    = 25;

  // correctable bit positions
  localparam int COR_RXE  = 0;
  localparam int COR_BTLP = 6;
  localparam int COR_BDLL = 7;
  localparam int COR_RRO  = 8;
  localparam int COR_RTO  = 12;
  localparam int COR_ADV  = 13;
  localparam int COR_INT  = 14;
  localparam int COR_HLO  = 15;

  localparam logic [31:0] UNC_SUP_MASK =
    (32'd1 << UNC_DLP) | (32'd1 << UNC_SDN) | (32'd1 << UNC_POISON) |
    (32'd1 << UNC_FCP) | (32'd1 << UNC_CTO) | (32'd1 << UNC_CA) |
    (32'd1 << UNC_UC)  | (32'd1 << UNC_RXO) | (32'd1 << UNC_MALF) |
    (32'd1 << UNC_ECRC) | (32'd1 << UNC_UR) | (32'd1 << UNC_ACS) |
    (32'd1 << UNC_INT) | (32'd1 << UNC_MCB) | (32'd1 << UNC_ATOP) |
    (32'd1 << UNC_PFX);

  localparam logic [31:0] COR_SUP_MASK =
    (32'd1 << COR_RXE) | (32'd1 << COR_BTLP) | (32'd1 << COR_BDLL) |
    (32'd1 << COR_RRO) | (32'd1 << COR_RTO) | (32'd1 << COR_ADV) |
    (32'd1 << COR_INT) | (32'd1 << COR_HLO);

  localparam logic [31:0] DEF_FATAL_MASK =
    (32'd1 << UNC_DLP) | (32'd1 << UNC_SDN) | (32'd1 << UNC_FCP) |
    (32'd1 << UNC_RXO) | (32'd1 << UNC_MALF) | (32'd1 << UNC_INT);

  localparam int DSTS_W   = 4;
  localparam int DSTS_COR = 0;
  localparam int DSTS_NF  = 1;
  localparam int DSTS_FAT = 2;
  localparam int DSTS_UR  = 3;

endpackage

// File: rtl/esc_classify.sv
module esc_classify
  import err_sig_pkg::*;
#(
  parameter int STS_W = 32
) (
  input  logic [STS_W-1:0] status,
  input  logic             is_cor,
  input  logic             maybe_adv,
  input  logic             cap_present,
  input  logic [STS_W-1:0] unc_sev,
  output logic             ok,
  output logic [STS_W-1:0] bit_oh,
  output logic             fatal,
  output logic             advisory,
  output logic             is_ur
);

  localparam logic [STS_W-1:0] UNC_SUP = STS_W'(UNC_SUP_MASK);
  localparam logic [STS_W-1:0] COR_SUP = STS_W'(COR_SUP_MASK);
  localparam logic [STS_W-1:0] DEF_FAT = STS_W'(DEF_FATAL_MASK);

  logic [STS_W-1:0] sup;
  logic [STS_W-1:0] sev_src;

  always_comb begin
    sup      = is_cor ? COR_SUP : UNC_SUP;
    bit_oh   = status & sup;
    ok       = (bit_oh != '0) && ((bit_oh & (bit_oh - 1'b1)) == '0);
    sev_src  = cap_present ? unc_sev : DEF_FAT;
    fatal    = !is_cor && ((bit_oh & sev_src) != '0);
    advisory = !is_cor && !fatal && maybe_adv;
    is_ur    = !is_cor && bit_oh[UNC_UR];
  end

endmodule

// File: rtl/esc_dev_gate.sv
module esc_dev_gate
  import err_sig_pkg::*;
#(
  parameter int STS_W = 32
) (
  input  logic              ok,
  input  logic [STS_W-1:0]  bit_oh,
  input  logic              is_cor,
  input  logic              fatal,
  input  logic              advisory,
  input  logic              is_ur,
  input  logic              cap_present,
  input  logic [STS_W-1:0]  cor_mask,
  input  logic [STS_W-1:0]  unc_mask,
  input  logic              cor_en,
  input  logic              nf_en,
  input  logic              fat_en,
  input  logic              ur_en,
  input  logic              serr_en,
  output logic [STS_W-1:0]  cor_set,
  output logic [STS_W-1:0]  unc_set,
  output logic [DSTS_W-1:0] dsts_set,
  output logic              log_req,
  output logic              msg_req,
  output sev_e              msg_sev
);

  localparam logic [STS_W-1:0] ADV_BIT = STS_W'(32'd1 << COR_ADV);

  logic [STS_W-1:0] cbit;
  logic             stop;

  always_comb begin
    cor_set  = '0;
    unc_set  = '0;
    dsts_set = '0;
    log_req  = 1'b0;
    msg_req  = 1'b0;
    msg_sev  = SEV_COR;
    stop     = 1'b0;
    cbit     = is_cor ? bit_oh : ADV_BIT;
    if (ok) begin
      if (is_cor || advisory) begin
        dsts_set[DSTS_COR] = 1'b1;
        dsts_set[DSTS_UR]  = is_ur;
        if (cap_present) begin
          cor_set = cbit;
          if ((cbit & cor_mask) != '0) begin
            stop = 1'b1;
          end else if (advisory) begin
            log_req = ((bit_oh & unc_mask) == '0);
            unc_set = bit_oh;
          end
        end
        if (!stop && !(is_ur && !ur_en) && cor_en) begin
          msg_req = 1'b1;
          msg_sev = SEV_COR;
        end
      end else begin
        dsts_set[DSTS_FAT] = fatal;
        dsts_set[DSTS_NF]  = !fatal;
        dsts_set[DSTS_UR]  = is_ur;
        if (cap_present) begin
          unc_set = bit_oh;
          if ((bit_oh & unc_mask) != '0) stop = 1'b1;
          else                           log_req = 1'b1;
        end
        if (!stop && !(is_ur && !ur_en && !serr_en)) begin
          if (fatal && (serr_en || fat_en)) begin
            msg_req = 1'b1;
            msg_sev = SEV_FATAL;
          end else if (!fatal && (serr_en || nf_en)) begin
            msg_req = 1'b1;
            msg_sev = SEV_NONFATAL;
          end
        end
      end
    end
  end

endmodule

// File: rtl/esc_fwd.sv
module esc_fwd
  import err_sig_pkg::*;
(
  input  logic msg_req,
  input  sev_e msg_sev,
  input  logic is_bridge,
  input  logic br_serr_en,
  input  logic serr_en,
  input  logic cor_en,
  input  logic nf_en,
  input  logic fat_en,
  output logic rcv_set,
  output logic sig_set,
  output logic fwd
);

  logic uncor;
  logic pass_br;
  logic sev_en;

  always_comb begin
    uncor   = (msg_sev != SEV_COR);
    pass_br = !is_bridge || br_serr_en;
    rcv_set = msg_req && is_bridge && uncor;
    sig_set = msg_req && pass_br && uncor && serr_en;
    unique case (msg_sev)
      SEV_FATAL:    sev_en = fat_en;
      SEV_NONFATAL: sev_en = nf_en;
      default:      sev_en = cor_en;
    endcase
    fwd = sig_set && sev_en;
  end

endmodule

// File: rtl/err_signal_ctrl.sv
module err_signal_ctrl
  import err_sig_pkg::*;
#(
  parameter int STS_W = 32,
  parameter int SRC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inj_valid,
  output logic              inj_ready,
  input  logic [STS_W-1:0]  inj_status,
  input  logic              inj_is_cor,
  input  logic              inj_maybe_adv,
  input  logic [SRC_W-1:0]  inj_src,
  input  logic              cap_present,
  input  logic [STS_W-1:0]  cfg_unc_mask,
  input  logic [STS_W-1:0]  cfg_unc_sev,
  input  logic [STS_W-1:0]  cfg_cor_mask,
  input  logic              cfg_cor_rep_en,
  input  logic              cfg_nf_rep_en,
  input  logic              cfg_fat_rep_en,
  input  logic              cfg_ur_rep_en,
  input  logic              cfg_serr_en,
  input  logic              port_is_bridge,
  input  logic              cfg_br_serr_en,
  output logic [DSTS_W-1:0] dev_sts,
  output logic [STS_W-1:0]  cor_sts,
  output logic [STS_W-1:0]  unc_sts,
  output logic              sig_serr,
  output logic              rcv_serr,
  output logic              log_pulse,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_sev,
  output logic [SRC_W-1:0]  msg_src,
  output logic              msg_fwd
);

  typedef enum logic {S_IDLE = 1'b0, S_HOLD = 1'b1} st_e;

  st_e              state_q, state_d;
  logic             accept;
  logic             c_ok, c_fatal, c_adv, c_ur;
  logic [STS_W-1:0] c_bit;
  logic [STS_W-1:0] g_cor_set, g_unc_set;
  logic [DSTS_W-1:0] g_dsts_set;
  logic             g_log, g_msg;
  sev_e             g_sev;
  logic             f_rcv, f_sig, f_fwd;

  logic [DSTS_W-1:0] dsts_q, dsts_d;
  logic [STS_W-1:0]  cor_q, cor_d, unc_q, unc_d;
  logic              sig_q, sig_d, rcv_q, rcv_d, log_q, log_d;
  sev_e              sev_q, sev_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic              fwd_q, fwd_d;

  esc_classify #(.STS_W(STS_W)) u_cls (
    .status      (inj_status),
    .is_cor      (inj_is_cor),
    .maybe_adv   (inj_maybe_adv),
    .cap_present (cap_present),
    .unc_sev     (cfg_unc_sev),
    .ok          (c_ok),
    .bit_oh      (c_bit),
    .fatal       (c_fatal),
    .advisory    (c_adv),
    .is_ur       (c_ur)
  );

  esc_dev_gate #(.STS_W(STS_W)) u_gate (
    .ok          (c_ok),
    .bit_oh      (c_bit),
    .is_cor      (inj_is_cor),
    .fatal       (c_fatal),
    .advisory    (c_adv),
    .is_ur       (c_ur),
    .cap_present (cap_present),
    .cor_mask    (cfg_cor_mask),
    .unc_mask    (cfg_unc_mask),
    .cor_en      (cfg_cor_rep_en),
    .nf_en       (cfg_nf_rep_en),
    .fat_en      (cfg_fat_rep_en),
    .ur_en       (cfg_ur_rep_en),
    .serr_en     (cfg_serr_en),
    .cor_set     (g_cor_set),
    .unc_set     (g_unc_set),
    .dsts_set    (g_dsts_set),
    .log_req     (g_log),
    .msg_req     (g_msg),
    .msg_sev     (g_sev)
  );

  esc_fwd u_fwd (
    .msg_req    (g_msg),
    .msg_sev    (g_sev),
    .is_bridge  (port_is_bridge),
    .br_serr_en (cfg_br_serr_en),
    .serr_en    (cfg_serr_en),
    .cor_en     (cfg_cor_rep_en),
    .nf_en      (cfg_nf_rep_en),
    .fat_en     (cfg_fat_rep_en),
    .rcv_set    (f_rcv),
    .sig_set    (f_sig),
    .fwd        (f_fwd)
  );

  assign accept = inj_valid && (state_q == S_IDLE);

  // next-state logic
  always_comb begin
    state_d = state_q;
    dsts_d  = dsts_q;
    cor_d   = cor_q;
    unc_d   = unc_q;
    sig_d   = sig_q;
    rcv_d   = rcv_q;
    sev_d   = sev_q;
    src_d   = src_q;
    fwd_d   = fwd_q;
    log_d   = accept && g_log;
    if (accept) begin
      dsts_d = dsts_q | g_dsts_set;
      cor_d  = cor_q | g_cor_set;
      unc_d  = unc_q | g_unc_set;
      sig_d  = sig_q | f_sig;
      rcv_d  = rcv_q | f_rcv;
      if (g_msg) begin
        state_d = S_HOLD;
        sev_d   = g_sev;
        src_d   = inj_src;
        fwd_d   = f_fwd;
      end
    end else if (state_q == S_HOLD && msg_ready) begin
      state_d = S_IDLE;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dsts_q  <= '0;
      cor_q   <= '0;
      unc_q   <= '0;
      sig_q   <= 1'b0;
      rcv_q   <= 1'b0;
      log_q   <= 1'b0;
      sev_q   <= SEV_COR;
      src_q   <= '0;
      fwd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      log_q   <= log_d;
      if (accept) begin
        dsts_q <= dsts_d;
        cor_q  <= cor_d;
        unc_q  <= unc_d;
        sig_q  <= sig_d;
        rcv_q  <= rcv_d;
        sev_q  <= sev_d;
        src_q  <= src_d;
        fwd_q  <= fwd_d;
      end
    end
  end

  assign inj_ready = (state_q == S_IDLE);
  assign msg_valid = (state_q == S_HOLD);
  assign msg_sev   = sev_q;
  assign msg_src   = src_q;
  assign msg_fwd   = fwd_q;
  assign dev_sts   = dsts_q;
  assign cor_sts   = cor_q;
  assign unc_sts   = unc_q;
  assign sig_serr  = sig_q;
  assign rcv_serr  = rcv_q;
  assign log_pulse = log_q;

endmodule

// File: rtl/err_signal_ctrl_chk.sv
module err_signal_ctrl_chk #(
  parameter int STS_W = 32,
  parameter int SRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inj_ready,
  input logic [STS_W-1:0] cor_sts,
  input logic [STS_W-1:0] unc_sts,
  input logic             sig_serr,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [1:0]       msg_sev,
  input logic [SRC_W-1:0] msg_src,
  input logic             msg_fwd
);

  assert_ready_vs_msg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !inj_ready);

  assert_msg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_sev) && $stable(msg_src)));

  assert_unc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((unc_sts & $past(unc_sts)) == $past(unc_sts)));

  assert_cor_one_new_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $onehot0(cor_sts & ~$past(cor_sts)));

  assert_unc_one_new_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $onehot0(unc_sts & ~$past(unc_sts)));

  assert_cor_not_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd0) |-> !msg_fwd);

  assert_sig_with_msg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_serr) |-> msg_valid);

endmodule

bind err_signal_ctrl err_signal_ctrl_chk #(.STS_W(STS_W), .SRC_W(SRC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inj_ready (inj_ready),
  .cor_sts   (cor_sts),
  .unc_sts   (unc_sts),
  .sig_serr  (sig_serr),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_sev   (msg_sev),
  .msg_src   (msg_src),
  .msg_fwd   (msg_fwd)
);

// File: tb/sim_err_signal_ctrl.sv
`timescale 1ns/1ps
module sim_err_signal_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inj_valid, inj_ready, inj_is_cor, inj_maybe_adv;
  logic [31:0] inj_status;
  logic [15:0] inj_src;
  logic        cap_present;
  logic [31:0] cfg_unc_mask, cfg_unc_sev, cfg_cor_mask;
  logic        cfg_cor_rep_en, cfg_nf_rep_en, cfg_fat_rep_en, cfg_ur_rep_en;
  logic        cfg_serr_en, port_is_bridge, cfg_br_serr_en;
  logic [3:0]  dev_sts;
  logic [31:0] cor_sts, unc_sts;
  logic        sig_serr, rcv_serr, log_pulse, msg_valid, msg_ready, msg_fwd;
  logic [1:0]  msg_sev;
  logic [15:0] msg_src;

  int n_chk = 0;
  int n_bad = 0;

  logic        g_msg, g_log, g_fwd, g_rdy;
  logic [1:0]  g_sev;
  logic [15:0] g_src;

  always #10 clk = ~clk;

  err_signal_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_status(inj_status),
    .inj_is_cor(inj_is_cor), .inj_maybe_adv(inj_maybe_adv), .inj_src(inj_src),
    .cap_present(cap_present), .cfg_unc_mask(cfg_unc_mask), .cfg_unc_sev(cfg_unc_sev),
    .cfg_cor_mask(cfg_cor_mask), .cfg_cor_rep_en(cfg_cor_rep_en),
    .cfg_nf_rep_en(cfg_nf_rep_en), .cfg_fat_rep_en(cfg_fat_rep_en),
    .cfg_ur_rep_en(cfg_ur_rep_en), .cfg_serr_en(cfg_serr_en),
    .port_is_bridge(port_is_bridge), .cfg_br_serr_en(cfg_br_serr_en),
    .dev_sts(dev_sts), .cor_sts(cor_sts), .unc_sts(unc_sts),
    .sig_serr(sig_serr), .rcv_serr(rcv_serr), .log_pulse(log_pulse),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_sev(msg_sev),
    .msg_src(msg_src), .msg_fwd(msg_fwd)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    inj_valid = 0; inj_status = 0; inj_is_cor = 0; inj_maybe_adv = 0; inj_src = 0;
    msg_ready = 0; cap_present = 1;
    cfg_unc_mask = 0; cfg_unc_sev = 0; cfg_cor_mask = 0;
    cfg_cor_rep_en = 0; cfg_nf_rep_en = 0; cfg_fat_rep_en = 0; cfg_ur_rep_en = 0;
    cfg_serr_en = 0; port_is_bridge = 0; cfg_br_serr_en = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive one error; sample the outputs the cycle after acceptance; retire any message
  task automatic inject(input logic [31:0] st, input logic cor, input logic adv, input logic [15:0] src);
    inj_status = st; inj_is_cor = cor; inj_maybe_adv = adv; inj_src = src;
    inj_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inj_valid = 1'b0;
    g_msg = msg_valid; g_sev = msg_sev; g_src = msg_src; g_fwd = msg_fwd;
    g_log = log_pulse; g_rdy = inj_ready;
    if (msg_valid) begin
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11", "reset inj_ready", inj_ready, 1);
    chk("R11", "reset msg_valid", msg_valid, 0);
    chk("R6", "reset dev_sts", dev_sts, 0);
    chk("R6", "reset unc_sts", unc_sts, 0);
    chk("R3", "reset cor_sts", cor_sts, 0);
  endtask

  task automatic t_reject();
    do_reset();
    cfg_cor_rep_en = 1; cfg_nf_rep_en = 1; cfg_fat_rep_en = 1;
    inject(32'h0000_0003, 0, 0, 16'h1);
    chk("R1", "unsupported unc bits msg", g_msg, 0);
    inject(32'h0000_0030, 0, 0, 16'h2);
    chk("R1", "two unc bits msg", g_msg, 0);
    chk("R1", "two unc bits log", g_log, 0);
    inject(32'h0000_0002, 1, 0, 16'h3);
    chk("R1", "unsupported cor bit msg", g_msg, 0);
    chk("R1", "unc_sts untouched", unc_sts, 0);
    chk("R1", "cor_sts untouched", cor_sts, 0);
    chk("R1", "dev_sts untouched", dev_sts, 0);
  endtask

  task automatic t_correctable();
    do_reset();
    cfg_cor_rep_en = 1;
    inject(32'h0000_0040, 1, 0, 16'h1234);
    chk("R3", "dev_sts cor", dev_sts, 4'b0001);
    chk("R3", "cor_sts bit6", cor_sts, 32'h40);
    chk("R4", "cor msg", g_msg, 1);
    chk("R4", "cor sev", g_sev, 0);
    chk("R11", "msg src", g_src, 16'h1234);
    chk("R11", "inj_ready low while msg", g_rdy, 0);
    chk("R10", "cor not forwarded", g_fwd, 0);
    cfg_cor_mask = 32'h80;
    inject(32'h0000_0080, 1, 0, 16'h5);
    chk("R3", "masked cor status", cor_sts, 32'hC0);
    chk("R3", "masked cor no msg", g_msg, 0);
    cfg_cor_rep_en = 0;
    inject(32'h0000_0001, 1, 0, 16'h6);
    chk("R4", "cor disabled no msg", g_msg, 0);
    chk("R4", "cor status still set", cor_sts, 32'hC1);
  endtask

  task automatic t_uncorrectable();
    do_reset();
    cfg_unc_sev = 32'h0004_0000; cfg_fat_rep_en = 1;
    inject(32'h0004_0000, 0, 0, 16'hA);
    chk("R6", "fatal dev_sts", dev_sts, 4'b0100);
    chk("R6", "fatal unc_sts", unc_sts, 32'h0004_0000);
    chk("R6", "fatal log", g_log, 1);
    chk("R8", "fatal msg", g_msg, 1);
    chk("R8", "fatal sev", g_sev, 2);
    chk("R12", "log pulse gone", log_pulse, 0);
    inject(32'h0000_1000, 0, 0, 16'hB);
    chk("R8", "nonfatal disabled no msg", g_msg, 0);
    chk("R6", "nonfatal dev_sts", dev_sts, 4'b0110);
    chk("R6", "nonfatal log", g_log, 1);
    cfg_unc_mask = 32'h0000_4000; cfg_nf_rep_en = 1;
    inject(32'h0000_4000, 0, 0, 16'hC);
    chk("R6", "masked unc status", unc_sts, 32'h0004_5000);
    chk("R6", "masked unc no log", g_log, 0);
    chk("R6", "masked unc no msg", g_msg, 0);
  endtask

  task automatic t_unsupported();
    do_reset();
    cfg_nf_rep_en = 1;
    inject(32'h0010_0000, 0, 0, 16'h7);
    chk("R7", "UR dev_sts", dev_sts, 4'b1010);
    chk("R7", "UR dropped", g_msg, 0);
    cfg_ur_rep_en = 1;
    inject(32'h0010_0000, 0, 0, 16'h8);
    chk("R7", "UR reported", g_msg, 1);
    chk("R8", "UR nonfatal sev", g_sev, 1);
  endtask

  task automatic t_advisory();
    do_reset();
    cfg_cor_rep_en = 1;
    inject(32'h0000_8000, 0, 1, 16'h21);
    chk("R5", "adv cor_sts bit13", cor_sts, 32'h2000);
    chk("R5", "adv unc_sts", unc_sts, 32'h8000);
    chk("R5", "adv dev_sts", dev_sts, 4'b0001);
    chk("R5", "adv log", g_log, 1);
    chk("R5", "adv msg cor", g_sev, 0);
    cfg_unc_mask = 32'h0001_0000;
    inject(32'h0001_0000, 0, 1, 16'h22);
    chk("R5", "adv masked status", unc_sts, 32'h0001_8000);
    chk("R5", "adv masked no log", g_log, 0);
    chk("R5", "adv masked msg", g_msg, 1);
    inject(32'h0010_0000, 0, 1, 16'h23);
    chk("R4", "adv UR no msg", g_msg, 0);
    chk("R5", "adv UR dev_sts", dev_sts, 4'b1001);
    cfg_unc_sev = 32'h0004_0000; cfg_fat_rep_en = 1;
    inject(32'h0004_0000, 0, 1, 16'h24);
    chk("R5", "fatal not advisory", g_sev, 2);
    chk("R5", "fatal dev_sts", dev_sts, 4'b1101);
  endtask

  task automatic t_bridge();
    do_reset();
    port_is_bridge = 1; cfg_serr_en = 1; cfg_fat_rep_en = 1; cfg_unc_sev = 32'h10;
    inject(32'h0000_0010, 0, 0, 16'h31);
    chk("R9", "rcv_serr", rcv_serr, 1);
    chk("R9", "sig blocked", sig_serr, 0);
    chk("R9", "fwd blocked", g_fwd, 0);
    chk("R8", "bridge msg fatal", g_sev, 2);
    cfg_br_serr_en = 1;
    inject(32'h0000_0010, 0, 0, 16'h32);
    chk("R10", "sig_serr set", sig_serr, 1);
    chk("R10", "fwd fatal", g_fwd, 1);
    do_reset();
    cfg_serr_en = 1; cfg_cor_rep_en = 1;
    inject(32'h0000_1000, 0, 0, 16'h33);
    chk("R8", "serr alone sends nonfatal", g_msg, 1);
    chk("R10", "sig_serr nonbridge", sig_serr, 1);
    chk("R10", "no fwd nf disabled", g_fwd, 0);
    chk("R9", "no rcv nonbridge", rcv_serr, 0);
    inject(32'h0000_0001, 1, 0, 16'h34);
    chk("R10", "cor no fwd", g_fwd, 0);
  endtask

  task automatic t_nocap();
    do_reset();
    cap_present = 0; cfg_unc_sev = 32'hFFFF_FFFF; cfg_unc_mask = 32'hFFFF_FFFF;
    cfg_nf_rep_en = 1; cfg_fat_rep_en = 1;
    inject(32'h0000_1000, 0, 0, 16'h41);
    chk("R2", "default nonfatal sev", g_sev, 1);
    chk("R2", "no cap unc_sts", unc_sts, 0);
    chk("R2", "no cap no log", g_log, 0);
    inject(32'h0002_0000, 0, 0, 16'h42);
    chk("R2", "default fatal sev", g_sev, 2);
    chk("R2", "no cap dev_sts", dev_sts, 4'b0110);
  endtask

  task automatic t_hold();
    do_reset();
    cfg_cor_rep_en = 1;
    inj_status = 32'h1; inj_is_cor = 1; inj_maybe_adv = 0; inj_src = 16'hBEEF;
    inj_valid = 1;
    @(posedge clk);
    @(negedge clk);
    inj_valid = 0;
    repeat (3) @(negedge clk);
    chk("R11", "msg held", msg_valid, 1);
    chk("R11", "src held", msg_src, 16'hBEEF);
    chk("R11", "ready held low", inj_ready, 0);
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
    chk("R11", "msg retired", msg_valid, 0);
    chk("R11", "ready back", inj_ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_reject();
    t_correctable();
    t_uncorrectable();
    t_unsupported();
    t_advisory();
    t_bridge();
    t_nocap();
    t_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule